// File: doc/BRIEF.md
# Converter Low-Power Mode Controller

This block decides when a sampling converter is fully active, partly powered down or fully powered down. Low-power states are chosen at the end of a read access. When the read strobe returns high with chip select asserted, the two low address bits select normal sampling, a light power-down or a deep power-down.

The light power-down (state `PD_NAP`) turns off the core but keeps the voltage reference running. Results are therefore good as soon as the core is back on. The deep power-down (state `PD_SLEEP`) also turns off the reference. After leaving it, a "result suspect" flag stays high for a set number of completed conversions while the reference settles. Starting a new conversion (a falling write strobe with chip select low) also ends any power-down. Every input is synchronous to `clk`, and every output is a plain logic level.

States are `PD_RUN`, `PD_NAP` and `PD_SLEEP`. Each of these transitions can be taken from any state:
- **read-commit to RUN**: code 00
- **read-commit to NAP**: code 01
- **read-commit to SLEEP**: code 10 or 11
- **write-wake to RUN**: conversion start

Leaving `PD_SLEEP` for any other state reloads the settle counter.

Top module: `pdn_ctrl`

## Requirements
- R1: After reset the state is `PD_RUN`: `core_en`=1, `ref_en`=1, `data_suspect`=0.
- R2: A read commit with `addr[1:0]`=01 moves to `PD_NAP`: `core_en`=0, `ref_en`=1. A read commit is a clock edge where all of these hold: `rd_n` is high, `rd_n` was low at the previous edge, and `cs_n` was low at the previous edge. The new state is visible after that edge.
- R3: A read commit with `addr[1:0]`=10 or 11 moves to `PD_SLEEP`: `core_en`=0, `ref_en`=0. `ref_en` is never low while `core_en` is high.
- R4: A read commit with `addr[1:0]`=00 moves to `PD_RUN` from any state.
- R5: `addr[2]` has no effect on the decoded mode.
- R6: A rising `rd_n` is ignored when `cs_n` was high at the previous edge.
- R7: A write start moves to `PD_RUN` at that edge and takes priority over a read commit at the same edge. A write start is an edge where `wr_n` is low, `wr_n` was high at the previous edge, and `cs_n` is low. A falling `wr_n` with `cs_n` high has no effect.
- R8: Leaving `PD_NAP` for `PD_RUN` never raises `data_suspect`.
- R9: Leaving `PD_SLEEP` raises `data_suspect`. It then counts down one step per edge with `conv_done` high in `PD_RUN`, and drops after the `SETTLE_CONV`-th such edge (default 10).
- R10: `conv_done` outside `PD_RUN` does not count down. Every exit from `PD_SLEEP`, including an exit to `PD_NAP`, reloads the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Read strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write (conversion start) strobe, active low |
| addr | input | ADDR_W | Address pins; bits 1:0 choose the mode |
| conv_done | input | 1 | One-cycle pulse per completed conversion |
| core_en | output | 1 | Converter core enable |
| ref_en | output | 1 | Reference enable |
| data_suspect | output | 1 | Results unreliable while the reference settles |

## Verification
The assertions check the following on every cycle:
- Each qualified read commit lands in the decoded state on the next edge.
- A write start always wakes the core.
- The reference is never off while the core is on.
- An exit from deep power-down always raises the suspect flag.
- The settle count cannot move down from zero without a reload.

Only the bench scenarios can show the following:
- The exact number of conversions the flag stays high.
- That the count pauses outside normal sampling and restarts on each sleep exit.
- That `addr[2]` and an unselected read are ignored.
- That a light power-down exit leaves the flag low.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
    typedef enum logic [1:0] {
        PD_RUN   = 2'd0,
        PD_NAP   = 2'd1,
        PD_SLEEP = 2'd2
    } pd_mode_e;
endpackage

// File: rtl/pdn_strobe_edge.sv
module pdn_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic rd_commit,
    output logic wr_start
);
    logic rd_q, cs_q, wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            cs_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            cs_q <= cs_n;
            wr_q <= wr_n;
        end
    end

    // Read commit: read returns high while chip select was held low.
    assign rd_commit = rd_n & ~rd_q & ~cs_q;
    // Conversion start: write falls with chip select low now.
    assign wr_start  = ~wr_n & wr_q & ~cs_n;
endmodule

// File: rtl/pdn_mode_decode.sv
module pdn_mode_decode
    import pdn_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output pd_mode_e          req
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^addr[ADDR_W-1:2];

    always_comb begin
        unique case (addr[1:0])
            2'b00:   req = PD_RUN;
            2'b01:   req = PD_NAP;
            default: req = PD_SLEEP;
        endcase
    end
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
    import pdn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_commit,
    input  logic     wr_start,
    input  pd_mode_e req,
    output pd_mode_e state,
    output logic     sleep_exit,
    output logic     core_en,
    output logic     ref_en
);
    pd_mode_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (wr_start)       state_nx = PD_RUN;
        else if (rd_commit) state_nx = req;
    end

    assign sleep_exit = (state == PD_SLEEP) && (state_nx != PD_SLEEP);

    always_comb begin
        core_en = 1'b0;
        ref_en  = 1'b0;
        unique case (state)
            PD_RUN:   begin core_en = 1'b1; ref_en = 1'b1; end
            PD_NAP:   begin core_en = 1'b0; ref_en = 1'b1; end
            PD_SLEEP: begin core_en = 1'b0; ref_en = 1'b0; end
            default:  begin core_en = 1'b0; ref_en = 1'b0; end
        endcase
    end

    AST_NAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_commit && !wr_start && req == PD_NAP) |=> (!core_en && ref_en)); // R2
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_commit && !wr_start && req == PD_SLEEP) |=> (!core_en && !ref_en)); // R3
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_commit && req == PD_RUN) |=> core_en); // R4
    AST_WRITE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (core_en && ref_en)); // R7
    AST_REF_BEFORE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> ref_en); // R3
endmodule

// File: rtl/pdn_settle_cnt.sv
module pdn_settle_cnt #(
    parameter int SETTLE_CONV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic conv_done,
    input  logic run_active,
    output logic suspect
);
    localparam int CNT_W = (SETTLE_CONV < 1) ? 1 : $clog2(SETTLE_CONV + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CONV);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (conv_done && run_active && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign suspect = (cnt != '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0)); // R9
    AST_HOLD_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !load) |=> $stable(cnt)); // R10
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
    import pdn_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SETTLE_CONV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              conv_done,
    output logic              core_en,
    output logic              ref_en,
    output logic              data_suspect
);
    logic     rd_commit, wr_start, sleep_exit;
    pd_mode_e req, state;

    pdn_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .cs_n(cs_n), .wr_n(wr_n),
        .rd_commit(rd_commit), .wr_start(wr_start)
    );

    pdn_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .req(req)
    );

    pdn_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_commit(rd_commit), .wr_start(wr_start),
        .req(req), .state(state), .sleep_exit(sleep_exit),
        .core_en(core_en), .ref_en(ref_en)
    );

    pdn_settle_cnt #(.SETTLE_CONV(SETTLE_CONV)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(sleep_exit), .conv_done(conv_done),
        .run_active(state == PD_RUN), .suspect(data_suspect)
    );

    AST_SLEEP_EXIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (SETTLE_CONV > 0 && !ref_en) |=> (!ref_en || data_suspect)); // R9
    AST_NAP_EXIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && !core_en && !data_suspect) |=> !data_suspect); // R8
endmodule

// File: tb/pdn_ctrl_test.sv
module pdn_ctrl_test;
    localparam int SETTLE = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, conv_done = 1'b0;
    logic [2:0] addr = 3'b000;
    logic core_en, ref_en, data_suspect;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    int  m_mode = 0;   // 0 run, 1 nap, 2 sleep
    int  m_cnt  = 0;
    bit  p_rd = 1, p_cs = 1, p_wr = 1;

    always #4 clk = ~clk;

    pdn_ctrl #(.ADDR_W(3), .SETTLE_CONV(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .conv_done(conv_done), .core_en(core_en),
        .ref_en(ref_en), .data_suspect(data_suspect)
    );

    function automatic logic [2:0] model_out();
        logic [2:0] o;
        o[2] = (m_mode == 0);
        o[1] = (m_mode != 2);
        o[0] = (m_cnt != 0);
        return o;
    endfunction

    always @(posedge clk) begin
        int nm;
        bit rr, ws;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; p_rd = 1; p_cs = 1; p_wr = 1;
        end else begin
            rr = rd_n && !p_rd && !p_cs;
            ws = !wr_n && p_wr && !cs_n;
            nm = m_mode;
            if (ws) nm = 0;
            else if (rr) nm = (addr[1:0] == 2'b00) ? 0 : (addr[1:0] == 2'b01) ? 1 : 2;
            if (m_mode == 2 && nm != 2) m_cnt = SETTLE;
            else if (conv_done && m_mode == 0 && m_cnt > 0) m_cnt = m_cnt - 1;
            m_mode = nm;
            p_rd = rd_n; p_cs = cs_n; p_wr = wr_n;
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if ({core_en, ref_en, data_suspect} !== model_out()) begin
                errors++;
                $display("FAIL %s: cycle compare actual=%b expected=%b", cur_req,
                         {core_en, ref_en, data_suspect}, model_out());
            end
        end
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    task automatic expect_out(string req, logic [2:0] exp);
        checks++;
        if ({core_en, ref_en, data_suspect} !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req,
                     {core_en, ref_en, data_suspect}, exp);
        end
    endtask

    task automatic rd_access(logic [2:0] a, logic cs);
        @(negedge clk); addr = a; cs_n = cs; rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic wr_access(logic cs);
        @(negedge clk); cs_n = cs; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic conv_pulse();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 3'b110);

        cur_req = "R2"; rd_access(3'b001, 1'b0); expect_out("R2", 3'b010);
        cur_req = "R8"; rd_access(3'b000, 1'b0); expect_out("R8", 3'b110);
        cur_req = "R5"; rd_access(3'b101, 1'b0); expect_out("R5", 3'b010);
        rd_access(3'b100, 1'b0); expect_out("R5", 3'b110);
        cur_req = "R3"; rd_access(3'b001, 1'b0);
        rd_access(3'b010, 1'b0); expect_out("R3", 3'b000);

        cur_req = "R9"; rd_access(3'b000, 1'b0); expect_out("R9", 3'b111);
        for (int i = 1; i < SETTLE; i++) conv_pulse();
        expect_out("R9", 3'b111);
        conv_pulse(); expect_out("R9", 3'b110);
        conv_pulse(); expect_out("R9", 3'b110);

        cur_req = "R10"; rd_access(3'b011, 1'b0); expect_out("R3", 3'b000);
        conv_pulse(); conv_pulse(); expect_out("R10", 3'b000);
        cur_req = "R7"; wr_access(1'b0); expect_out("R7", 3'b111);
        conv_pulse(); conv_pulse(); conv_pulse();
        cur_req = "R10"; rd_access(3'b110, 1'b0);
        rd_access(3'b001, 1'b0); expect_out("R10", 3'b011);
        for (int i = 0; i < 4; i++) conv_pulse();
        expect_out("R10", 3'b011);
        rd_access(3'b000, 1'b0);
        for (int i = 1; i < SETTLE; i++) conv_pulse();
        expect_out("R10", 3'b111);
        conv_pulse(); expect_out("R10", 3'b110);

        cur_req = "R6"; rd_access(3'b001, 1'b1); expect_out("R6", 3'b110);
        rd_access(3'b010, 1'b1); expect_out("R6", 3'b110);

        cur_req = "R7"; rd_access(3'b001, 1'b0);
        wr_access(1'b1); expect_out("R7", 3'b010);
        wr_access(1'b0); expect_out("R7", 3'b110);

        // write start and read commit on the same edge: write wins
        rd_access(3'b001, 1'b0); expect_out("R2", 3'b010);
        @(negedge clk); addr = 3'b010; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
        expect_out("R7", 3'b110);

        cur_req = "R1";
        repeat (3) @(negedge clk);
        report();
    end
endmodule